// File: doc/BRIEF.md
# Time-Base Tick Event Generator

This block watches a free-running 64-bit time-base value and produces a periodic monitor event each time one chosen bit of that value changes from 0 to 1. A 2-bit selector chooses which bit is watched, so software can trade event rate against resolution. A master enable gates the event. Two control bits then decide what the event does: it can stop the event counters with a one-cycle freeze pulse, or it can raise a monitor interrupt.

The interrupt condition is stored in a sticky pending flag. The flag is set by an event even while the global interrupt enable is low. The request output is only driven while that enable is high. Software clears the flag with a one-cycle clear pulse.

Edge detection compares the tap value sampled on the previous clock against the bit selected now. For this reason, changing the selector while the block is enabled can produce a false rising edge, and the configured action then fires at once. The counters themselves lie outside this block.

Top module: `tbase_tick_monitor`

## Requirements
- R1: The selector picks the watched bit of `tbase`. Code 0 picks bit 0, code 1 picks bit 8, code 2 picks bit 12 and code 3 picks bit 16. A rise on any other bit position of the four produces no event.
- R2: `freeze_pulse` is high, combinationally, in every cycle where all of these hold: the selected bit is 1, the tap value sampled at the previous clock edge was 0, `tick_en` is 1 and `freeze_on_tick` is 1.
- R3: A 1-to-0 change of the selected bit, or a bit that stays at 1, produces no event.
- R4: While `tick_en` is 0, a rising tap produces no freeze pulse and does not set the pending flag.
- R5: With `freeze_on_tick` at 0, an event gives no freeze pulse. With `irq_on_tick` at 0, an event does not set the pending flag.
- R6: An event with `irq_on_tick` at 1 sets the pending flag at the next clock edge. `irq_req` equals the pending flag AND `glob_irq_en`. A flag set while `glob_irq_en` is 0 is held and appears on `irq_req` once `glob_irq_en` rises.
- R7: The pending flag stays set until `pend_clr` is 1 at a clock edge. The clear wins over an event in the same cycle.
- R8: Edge detection compares the previously sampled tap value with the currently selected bit. A selector change that moves from a 0 tap to a 1 tap therefore gives an immediate event. A change between two taps that are both 1 gives none.
- R9: While `rst_n` is 0, both outputs are 0. In the first cycle after reset is released, no event is produced even if the selected bit is 1.
- R10: Bits of `tbase` that are not currently selected have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbase | input | 64 | Free-running time-base value |
| tap_sel | input | 2 | Tap bit selector |
| tick_en | input | 1 | Master enable for tick events |
| freeze_on_tick | input | 1 | An event pulses `freeze_pulse` |
| irq_on_tick | input | 1 | An event sets the pending interrupt flag |
| glob_irq_en | input | 1 | Global interrupt enable (unmask) |
| pend_clr | input | 1 | Clear pulse for the pending flag |
| freeze_pulse | output | 1 | Counter freeze pulse, one cycle per event |
| irq_req | output | 1 | Monitor interrupt request |

## Verification
The assertions assume that `tbase`, `tap_sel` and the control bits are stable around each clock edge and that `pend_clr` is a plain level sampled at the edge. Under these assumptions the sticky and clear properties reduce to single-edge relations. The stimulus drives every input on the falling edge and holds it through the next rising edge. It also moves the tap bit only between clock edges, one step at a time. Each event cycle is therefore a single, well-defined cycle, and the flag and request checks are sampled one edge later.

// File: rtl/tbt_pkg.sv
// Package: shared constants and the selector-to-bit mapping for the
// time-base tick event generator. Assumes a 2-bit selector over four taps.
package tbt_pkg;
    localparam int TB_W     = 64;
    localparam int SEL_W    = 2;
    localparam int NUM_TAPS = 1 << SEL_W;

    // Map a selector code to the watched bit position, counted from the LSB.
    function automatic int tap_position(input logic [SEL_W-1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 8;
            2'd2:    return 12;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/tbt_tap_mux.sv
// Module: picks the watched time-base bit from the selector code.
// Assumes every tap position returned by the package lies below TBW.
module tbt_tap_mux
    import tbt_pkg::*;
#(
    parameter int TBW = TB_W,
    parameter int SW  = SEL_W
) (
    input  logic [TBW-1:0] tbase,
    input  logic [SW-1:0]  sel,
    output logic           tap_bit
);
    localparam int NT = 1 << SW;

    logic [NT-1:0] taps;
    logic          unused_tbase;

    // One wire per selectable tap, built from the package mapping.
    for (genvar g = 0; g < NT; g++) begin : g_tap
        assign taps[g] = tbase[tap_position(SW'(g))];
    end

    // Fold the remaining bits so that they count as intentionally unused.
    assign unused_tbase = ^tbase;

    // Select the active tap.
    assign tap_bit = taps[sel];
endmodule

// File: rtl/tbt_rise_detect.sv
// Module: rising-edge detector on the selected tap. It compares the tap
// sampled at the last edge with the tap selected now. It stays quiet
// until one sample has been taken after reset.
module tbt_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_bit,
    input  logic enable,
    output logic tick
);
    logic prev_q;
    logic primed_q;

    // Sample the tap every clock and mark that a valid sample exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= tap_bit;
            primed_q <= 1'b1;
        end
    end

    // Event: tap is 1 now, was 0 at the previous sample, block enabled.
    assign tick = rst_n & primed_q & enable & tap_bit & ~prev_q;

    AST_TICK_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> prev_q);                                        // R2
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed_q) |-> $past(!tick));                        // R9
endmodule

// File: rtl/tbt_irq_hold.sv
// Module: sticky pending interrupt flag with clear priority. The request
// is masked by the global interrupt enable. Assumes clr is a one-cycle pulse.
module tbt_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr,
    input  logic unmask,
    output logic irq
);
    logic pend_q;

    // Hold the pending flag; a clear takes priority over a new set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (clr)
            pend_q <= 1'b0;
        else if (set_req)
            pend_q <= 1'b1;
    end

    // Deliver the request only while interrupts are unmasked.
    assign irq = rst_n & pend_q & unmask;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !clr |=> pend_q);                               // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend_q);                                         // R7
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !unmask |-> !irq);                                        // R6
endmodule

// File: rtl/tbase_tick_monitor.sv
// Module: top of the time-base tick event generator. It chooses a tap,
// detects its rising edge, and routes the event to a freeze pulse and/or
// a pending interrupt. Assumes all inputs are synchronous to clk.
module tbase_tick_monitor
    import tbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TB_W-1:0]   tbase,
    input  logic [SEL_W-1:0]  tap_sel,
    input  logic              tick_en,
    input  logic              freeze_on_tick,
    input  logic              irq_on_tick,
    input  logic              glob_irq_en,
    input  logic              pend_clr,
    output logic              freeze_pulse,
    output logic              irq_req
);
    logic tap_bit;
    logic tick;

    tbt_tap_mux #(.TBW(TB_W), .SW(SEL_W)) u_mux (
        .tbase   (tbase),
        .sel     (tap_sel),
        .tap_bit (tap_bit)
    );

    tbt_rise_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_bit (tap_bit),
        .enable  (tick_en),
        .tick    (tick)
    );

    tbt_irq_hold u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (tick & irq_on_tick),
        .clr     (pend_clr),
        .unmask  (glob_irq_en),
        .irq     (irq_req)
    );

    // Route the event to the freeze action in the same cycle.
    assign freeze_pulse = tick & freeze_on_tick;

    AST_FREEZE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_pulse |-> tick_en && freeze_on_tick);              // R4
    AST_RESET_SILENT: assert property (@(posedge clk)
        !rst_n |-> !freeze_pulse && !irq_req);                    // R9
endmodule

// File: tb/tbase_tick_monitor_test.sv
module tbase_tick_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tbase = '0;
    logic [1:0]  tap_sel = '0;
    logic        tick_en = 1'b0;
    logic        freeze_on_tick = 1'b0;
    logic        irq_on_tick = 1'b0;
    logic        glob_irq_en = 1'b0;
    logic        pend_clr = 1'b0;
    logic        freeze_pulse;
    logic        irq_req;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    tbase_tick_monitor uut (
        .clk(clk), .rst_n(rst_n), .tbase(tbase), .tap_sel(tap_sel),
        .tick_en(tick_en), .freeze_on_tick(freeze_on_tick),
        .irq_on_tick(irq_on_tick), .glob_irq_en(glob_irq_en),
        .pend_clr(pend_clr), .freeze_pulse(freeze_pulse), .irq_req(irq_req)
    );

    // Tap bit for each selector code, taken from R1.
    function automatic int exp_pos(input int code);
        return (code == 0) ? 0 : (code == 1) ? 8 : (code == 2) ? 12 : 16;
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled at the negedge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: in reset the outputs are quiet even with the tap high.
        tbase = 64'h1; tick_en = 1'b1; freeze_on_tick = 1'b1;
        irq_on_tick = 1'b1; glob_irq_en = 1'b1;
        cyc(); cyc();
        chk(freeze_pulse, 1'b0, "R9 reset freeze");
        chk(irq_req, 1'b0, "R9 reset irq");
        rst_n = 1'b1; #1;
        chk(freeze_pulse, 1'b0, "R9 first cycle after reset");
        cyc();
        chk(freeze_pulse, 1'b0, "R9 held high tap");
        chk(irq_req, 1'b0, "R9 no pending after reset");
        irq_on_tick = 1'b0;

        // R1/R2/R3/R10: every selector against a rise on every tap position.
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                tap_sel = 2'(s); tbase = '0; cyc();
                tbase = 64'h1 << exp_pos(p); #1;
                chk(freeze_pulse, (s == p), (s == p) ? "R2 rise on tap" : "R1 other tap");
                cyc();
                chk(freeze_pulse, 1'b0, "R3 tap stays high");
                tbase = '0; #1;
                chk(freeze_pulse, 1'b0, "R3 falling tap");
            end
            // R10: all other bits rise together while the tap stays 0.
            tbase = '0; cyc();
            tbase = ~(64'h1 << exp_pos(s)); #1;
            chk(freeze_pulse, 1'b0, "R10 non-selected bits");
            tbase = '0; cyc();
        end

        // R5: freeze action off.
        tap_sel = 2'd0; freeze_on_tick = 1'b0; tbase = 64'h1; #1;
        chk(freeze_pulse, 1'b0, "R5 freeze disabled");
        cyc(); tbase = '0; cyc();

        // R4: enable off blocks both actions.
        tick_en = 1'b0; freeze_on_tick = 1'b1; irq_on_tick = 1'b1; tbase = 64'h1; #1;
        chk(freeze_pulse, 1'b0, "R4 disabled freeze");
        cyc();
        chk(irq_req, 1'b0, "R4 disabled pend");
        tbase = '0; tick_en = 1'b1; cyc();

        // R6: event while masked is held, then delivered on unmask.
        glob_irq_en = 1'b0; freeze_on_tick = 1'b0; tbase = 64'h1; cyc();
        chk(irq_req, 1'b0, "R6 masked");
        tbase = '0; cyc(); cyc();
        chk(irq_req, 1'b0, "R6 still masked");
        glob_irq_en = 1'b1; #1;
        chk(irq_req, 1'b1, "R6 delivered on unmask");
        cyc();
        chk(irq_req, 1'b1, "R7 sticky");

        // R7: clear pulse, then clear against a simultaneous event.
        pend_clr = 1'b1; cyc(); pend_clr = 1'b0; #1;
        chk(irq_req, 1'b0, "R7 cleared");
        tbase = 64'h1; pend_clr = 1'b1; cyc(); pend_clr = 1'b0; #1;
        chk(irq_req, 1'b0, "R7 clear beats event");
        tbase = '0; cyc();

        // R5: interrupt action off.
        irq_on_tick = 1'b0; tbase = 64'h1; cyc();
        chk(irq_req, 1'b0, "R5 irq disabled");
        tbase = '0; cyc();

        // R8: selector change from a low tap to a high tap fires at once.
        freeze_on_tick = 1'b1; tap_sel = 2'd0; tbase = 64'h100; cyc();
        chk(freeze_pulse, 1'b0, "R8 before change");
        tap_sel = 2'd1; #1;
        chk(freeze_pulse, 1'b1, "R8 false edge on change");
        cyc();
        tbase = 64'h1101; cyc();
        tap_sel = 2'd2; #1;
        chk(freeze_pulse, 1'b0, "R8 change between high taps");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule